// File: doc/BRIEF.md
# Tag-Waking Operand Holding Pool

This block holds instructions for a single functional unit between the moment they leave the issue stage and the moment their operands are all known. Each of its four slots receives an operation code, two source operands and the reorder-buffer entry number that will receive the result. A source operand arrives either as a finished value or as the reorder-buffer entry number of the instruction that still has to produce it. While a slot holds an operand that is still missing, it watches the shared result bus. When a broadcast carries the entry number the slot is waiting for, the slot copies the value in.

When every operand of a slot is present, the slot becomes a candidate for the functional unit. One candidate leaves per cycle. The slot does not free itself when it is dispatched. It stays occupied until the unit's result for its destination entry appears on the result bus, so the pool also tracks the instructions that are in flight. A flush wipes every slot at once, for example after a mispredicted branch.

The issue side uses a valid/ready handshake. `issue_ready` is the back-pressure signal: a transfer happens only in a cycle where `issue_valid` and `issue_ready` are both high. The upstream stage must hold its fields stable until that cycle. The dispatch side uses the same handshake. The pool asserts `disp_valid` with its fields, and the unit takes them in a cycle where `disp_ready` is high. While `disp_ready` stays low, the offered slot stays queued. The fields on offer may change if a lower-numbered slot becomes ready in the meantime. `flush`, `rob_room`, the result bus and `free_any` are plain level signals.

Top module: `resv_station`

## Requirements
- R1: `issue_ready` is high exactly when `flush` is low, `rob_room` is high and at least one slot is unoccupied. An accepted instruction goes into the lowest-numbered unoccupied slot.
- R2: For each source, a high `issue_x_ready` means `issue_x_value` is the operand. A low one means `issue_x_tag` names the producing entry. `issue_dest` is kept with the slot and is presented on `disp_dest` when that slot is dispatched.
- R3: A slot is offered on `disp_valid` only once both of its operands are present. It is never offered again after the unit has accepted it.
- R4: A queued slot whose operand is missing captures `res_data` at the next clock edge when `res_valid` is high and `res_tag` equals the awaited tag. The captured value is what `disp_a` or `disp_b` later shows.
- R5: If a broadcast whose tag matches an incoming missing operand arrives in the same cycle as that issue, the new slot holds the operand as present, with the broadcast data.
- R6: When several slots are ready, the lowest-numbered one is offered. The unit accepts it in a cycle where `disp_valid` and `disp_ready` are both high.
- R7: A dispatched slot becomes unoccupied after the clock edge at which `res_valid` is high with `res_tag` equal to its destination entry. `free_any` is high whenever at least one slot is unoccupied.
- R8: While `flush` is high, `issue_ready` and `disp_valid` are low. After that edge every slot is unoccupied.
- R9: A broadcast has no effect on an operand that waits for a different tag. It also has no effect on a slot that has not yet been dispatched, even when that slot's destination matches the broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard every slot |
| issue_valid | input | 1 | Issue request present |
| issue_ready | output | 1 | Issue request can be taken |
| rob_room | input | 1 | Reorder buffer has a free entry |
| issue_op | input | OP_W | Operation code |
| issue_a_ready | input | 1 | Source A carries a value |
| issue_a_value | input | DATA_W | Source A value |
| issue_a_tag | input | TAG_W | Source A producer entry |
| issue_b_ready | input | 1 | Source B carries a value |
| issue_b_value | input | DATA_W | Source B value |
| issue_b_tag | input | TAG_W | Source B producer entry |
| issue_dest | input | TAG_W | Destination reorder-buffer entry |
| res_valid | input | 1 | Result bus carries a result |
| res_tag | input | TAG_W | Entry the result belongs to |
| res_data | input | DATA_W | Result value |
| disp_valid | output | 1 | A ready slot is offered |
| disp_ready | input | 1 | Functional unit takes the offer |
| disp_op | output | OP_W | Offered operation code |
| disp_a | output | DATA_W | Offered source A |
| disp_b | output | DATA_W | Offered source B |
| disp_dest | output | TAG_W | Offered destination entry |
| free_any | output | 1 | At least one slot is unoccupied |

## Verification
The issue and the result-bus snoop can land in the same cycle. A missing operand must then take the broadcast value instead of a tag, and a broadcast can also free one slot while another is being filled. The bench provokes this with a directed issue whose awaited tag is on the bus in the same cycle. Random traffic also puts broadcasts alongside issues, biased toward the destinations of slots already in flight. Every cycle, a slot model in the bench predicts the offered fields and the handshake flags, and the bench compares them against the ports.

// File: rtl/resv_station_pkg.sv
package resv_station_pkg;
  localparam int unsigned NUM_SRC = 2;

  typedef enum logic [1:0] {
    SLOT_IDLE   = 2'd0,
    SLOT_QUEUED = 2'd1,
    SLOT_SENT   = 2'd2
  } slot_state_e;
endpackage

// File: rtl/resv_pick.sv
module resv_pick #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        gnt[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  assign any = |req;
endmodule

// File: rtl/resv_slot.sv
module resv_slot
  import resv_station_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned OP_W   = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            flush,
  input  logic                            alloc,
  input  logic [OP_W-1:0]                 in_op,
  input  logic [NUM_SRC-1:0]              in_rdy,
  input  logic [NUM_SRC-1:0][DATA_W-1:0]  in_val,
  input  logic [NUM_SRC-1:0][TAG_W-1:0]   in_tag,
  input  logic [TAG_W-1:0]                in_dest,
  input  logic                            res_valid,
  input  logic [TAG_W-1:0]                res_tag,
  input  logic [DATA_W-1:0]               res_data,
  input  logic                            grant,
  output logic                            busy,
  output logic                            ready,
  output logic [OP_W-1:0]                 op,
  output logic [NUM_SRC-1:0][DATA_W-1:0]  val,
  output logic [TAG_W-1:0]                dest
);
  slot_state_e                     state_q;
  logic [NUM_SRC-1:0]              rdy_q;
  logic [NUM_SRC-1:0][DATA_W-1:0]  val_q;
  logic [NUM_SRC-1:0][TAG_W-1:0]   tag_q;
  logic [OP_W-1:0]                 op_q;
  logic [TAG_W-1:0]                dest_q;
  logic                            result_seen;

  assign result_seen = res_valid && (res_tag == dest_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SLOT_IDLE;
    end else if (flush) begin
      state_q <= SLOT_IDLE;
    end else begin
      unique case (state_q)
        SLOT_IDLE:   if (alloc)       state_q <= SLOT_QUEUED;
        SLOT_QUEUED: if (grant)       state_q <= SLOT_SENT;
        SLOT_SENT:   if (result_seen) state_q <= SLOT_IDLE;
        default:                      state_q <= SLOT_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= '0;
      dest_q <= '0;
    end else if (alloc) begin
      op_q   <= in_op;
      dest_q <= in_dest;
    end
  end

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    logic hit_new, hit_held;
    assign hit_new  = res_valid && (res_tag == in_tag[k]);
    assign hit_held = res_valid && (res_tag == tag_q[k]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rdy_q[k] <= 1'b0;
        val_q[k] <= '0;
        tag_q[k] <= '0;
      end else if (alloc) begin
        tag_q[k] <= in_tag[k];
        if (in_rdy[k]) begin
          rdy_q[k] <= 1'b1;
          val_q[k] <= in_val[k];
        end else if (hit_new) begin
          rdy_q[k] <= 1'b1;
          val_q[k] <= res_data;
        end else begin
          rdy_q[k] <= 1'b0;
        end
      end else if (state_q == SLOT_QUEUED && !rdy_q[k] && hit_held) begin
        rdy_q[k] <= 1'b1;
        val_q[k] <= res_data;
      end
    end

    p_snoop_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SLOT_QUEUED && !alloc && !flush && !rdy_q[k] && hit_held)
      |=> (rdy_q[k] && val_q[k] == $past(res_data)));

    p_same_cycle_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc && !in_rdy[k] && hit_new)
      |=> (rdy_q[k] && val_q[k] == $past(res_data)));

    p_other_tag_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SLOT_QUEUED && !alloc && !rdy_q[k] && !hit_held)
      |=> (!rdy_q[k] && $stable(tag_q[k])));
  end

  assign busy  = (state_q != SLOT_IDLE);
  assign ready = (state_q == SLOT_QUEUED) && (&rdy_q);
  assign op    = op_q;
  assign val   = val_q;
  assign dest  = dest_q;

  p_alloc_only_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> (state_q == SLOT_IDLE));

  p_grant_needs_operands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (state_q == SLOT_QUEUED && (&rdy_q)));

  p_free_on_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SLOT_SENT && result_seen) |=> (state_q == SLOT_IDLE));

  p_queued_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SLOT_QUEUED && !grant && !flush) |=> (state_q == SLOT_QUEUED));
endmodule

// File: rtl/resv_station.sv
module resv_station
  import resv_station_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned TAG_W     = 4,
  parameter int unsigned OP_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              issue_valid,
  output logic              issue_ready,
  input  logic              rob_room,
  input  logic [OP_W-1:0]   issue_op,
  input  logic              issue_a_ready,
  input  logic [DATA_W-1:0] issue_a_value,
  input  logic [TAG_W-1:0]  issue_a_tag,
  input  logic              issue_b_ready,
  input  logic [DATA_W-1:0] issue_b_value,
  input  logic [TAG_W-1:0]  issue_b_tag,
  input  logic [TAG_W-1:0]  issue_dest,
  input  logic              res_valid,
  input  logic [TAG_W-1:0]  res_tag,
  input  logic [DATA_W-1:0] res_data,
  output logic              disp_valid,
  input  logic              disp_ready,
  output logic [OP_W-1:0]   disp_op,
  output logic [DATA_W-1:0] disp_a,
  output logic [DATA_W-1:0] disp_b,
  output logic [TAG_W-1:0]  disp_dest,
  output logic              free_any
);
  logic [NUM_SLOTS-1:0] busy_vec, ready_vec, idle_vec;
  logic [NUM_SLOTS-1:0] free_gnt, disp_gnt, alloc_vec, grant_vec;
  logic                 any_idle, any_ready, issue_fire, disp_fire;

  logic [NUM_SRC-1:0]             in_rdy;
  logic [NUM_SRC-1:0][DATA_W-1:0] in_val;
  logic [NUM_SRC-1:0][TAG_W-1:0]  in_tag;

  logic [OP_W-1:0]                s_op   [NUM_SLOTS];
  logic [NUM_SRC-1:0][DATA_W-1:0] s_val  [NUM_SLOTS];
  logic [TAG_W-1:0]               s_dest [NUM_SLOTS];

  assign in_rdy = {issue_b_ready, issue_a_ready};
  assign in_val = {issue_b_value, issue_a_value};
  assign in_tag = {issue_b_tag, issue_a_tag};

  assign idle_vec = ~busy_vec;

  resv_pick #(.N(NUM_SLOTS)) u_free_pick (
    .req (idle_vec),
    .gnt (free_gnt),
    .any (any_idle)
  );

  resv_pick #(.N(NUM_SLOTS)) u_disp_pick (
    .req (ready_vec),
    .gnt (disp_gnt),
    .any (any_ready)
  );

  assign free_any    = any_idle;
  assign issue_ready = !flush && rob_room && any_idle;
  assign issue_fire  = issue_valid && issue_ready;
  assign disp_valid  = !flush && any_ready;
  assign disp_fire   = disp_valid && disp_ready;
  assign alloc_vec   = issue_fire ? free_gnt : '0;
  assign grant_vec   = disp_fire  ? disp_gnt : '0;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    resv_slot #(
      .DATA_W (DATA_W),
      .TAG_W  (TAG_W),
      .OP_W   (OP_W)
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .alloc     (alloc_vec[i]),
      .in_op     (issue_op),
      .in_rdy    (in_rdy),
      .in_val    (in_val),
      .in_tag    (in_tag),
      .in_dest   (issue_dest),
      .res_valid (res_valid),
      .res_tag   (res_tag),
      .res_data  (res_data),
      .grant     (grant_vec[i]),
      .busy      (busy_vec[i]),
      .ready     (ready_vec[i]),
      .op        (s_op[i]),
      .val       (s_val[i]),
      .dest      (s_dest[i])
    );
  end

  always_comb begin
    disp_op   = '0;
    disp_a    = '0;
    disp_b    = '0;
    disp_dest = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      disp_op   = disp_op   | ({OP_W{disp_gnt[i]}}   & s_op[i]);
      disp_a    = disp_a    | ({DATA_W{disp_gnt[i]}} & s_val[i][0]);
      disp_b    = disp_b    | ({DATA_W{disp_gnt[i]}} & s_val[i][1]);
      disp_dest = disp_dest | ({TAG_W{disp_gnt[i]}}  & s_dest[i]);
    end
  end

  p_issue_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |-> (rob_room && (busy_vec != '1)));

  p_single_dispatch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  p_flush_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!disp_valid && !issue_ready));

  p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (busy_vec == '0));
endmodule

// File: tb/resv_station_test.sv
module resv_station_test;
  localparam int N  = 4;
  localparam int DW = 32;
  localparam int TW = 4;
  localparam int OW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0, issue_valid = 1'b0, rob_room = 1'b1;
  logic [OW-1:0] issue_op = '0;
  logic issue_a_ready = 1'b0, issue_b_ready = 1'b0;
  logic [DW-1:0] issue_a_value = '0, issue_b_value = '0;
  logic [TW-1:0] issue_a_tag = '0, issue_b_tag = '0, issue_dest = '0;
  logic res_valid = 1'b0;
  logic [TW-1:0] res_tag = '0;
  logic [DW-1:0] res_data = '0;
  logic disp_ready = 1'b0;
  logic issue_ready, disp_valid, free_any;
  logic [OW-1:0] disp_op;
  logic [DW-1:0] disp_a, disp_b;
  logic [TW-1:0] disp_dest;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  resv_station #(.NUM_SLOTS(N), .DATA_W(DW), .TAG_W(TW), .OP_W(OW)) uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .issue_valid(issue_valid), .issue_ready(issue_ready), .rob_room(rob_room),
    .issue_op(issue_op),
    .issue_a_ready(issue_a_ready), .issue_a_value(issue_a_value), .issue_a_tag(issue_a_tag),
    .issue_b_ready(issue_b_ready), .issue_b_value(issue_b_value), .issue_b_tag(issue_b_tag),
    .issue_dest(issue_dest),
    .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
    .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_op(disp_op), .disp_a(disp_a), .disp_b(disp_b), .disp_dest(disp_dest),
    .free_any(free_any)
  );

  // Bench slot model: 0 empty, 1 queued, 2 sent
  int            m_st   [N];
  logic [OW-1:0] m_op   [N];
  logic [TW-1:0] m_dest [N];
  logic          m_rdy  [N][2];
  logic [DW-1:0] m_val  [N][2];
  logic [TW-1:0] m_tag  [N][2];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int m_first_free();
    for (int i = 0; i < N; i++) if (m_st[i] == 0) return i;
    return -1;
  endfunction

  function automatic int m_first_ready();
    for (int i = 0; i < N; i++)
      if (m_st[i] == 1 && m_rdy[i][0] && m_rdy[i][1]) return i;
    return -1;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < N; i++) begin
      m_st[i] = 0;
      m_rdy[i][0] = 1'b0;
      m_rdy[i][1] = 1'b0;
    end
  endtask

  task automatic idle_inputs();
    flush = 1'b0; issue_valid = 1'b0; rob_room = 1'b1;
    issue_a_ready = 1'b0; issue_b_ready = 1'b0;
    res_valid = 1'b0; disp_ready = 1'b0;
  endtask

  // Compare all outputs with the model, advance the model, cross one clock edge.
  task automatic step(input bit waited = 1'b0);
    bit exp_free, exp_ir, fire_i, fire_d;
    int g, fs;
    logic [DW-1:0] iv [2];
    logic [TW-1:0] it [2];
    logic          ir [2];
    if (!waited) #1;
    fs = m_first_free();
    exp_free = (fs >= 0);
    exp_ir = !flush && rob_room && exp_free;
    g = flush ? -1 : m_first_ready();
    chk(issue_ready === exp_ir, "R1", "issue_ready", 32'(issue_ready), 32'(exp_ir));
    chk(free_any === exp_free, "R7", "free_any", 32'(free_any), 32'(exp_free));
    chk(disp_valid === (g >= 0), "R3", "disp_valid", 32'(disp_valid), 32'(g >= 0));
    if (g >= 0 && disp_valid === 1'b1) begin
      chk(disp_dest === m_dest[g], "R2", "disp_dest", 32'(disp_dest), 32'(m_dest[g]));
      chk(disp_op === m_op[g], "R6", "disp_op", 32'(disp_op), 32'(m_op[g]));
      chk(disp_a === m_val[g][0], "R4", "disp_a", disp_a, m_val[g][0]);
      chk(disp_b === m_val[g][1], "R4", "disp_b", disp_b, m_val[g][1]);
    end
    fire_i = issue_valid && exp_ir;
    fire_d = (g >= 0) && disp_ready;
    if (flush) begin
      model_clear();
    end else begin
      for (int i = 0; i < N; i++) begin
        int old;
        old = m_st[i];
        if (old == 1) begin
          for (int k = 0; k < 2; k++)
            if (!m_rdy[i][k] && res_valid && m_tag[i][k] == res_tag) begin
              m_rdy[i][k] = 1'b1;
              m_val[i][k] = res_data;
            end
          if (fire_d && i == g) m_st[i] = 2;
        end else if (old == 2 && res_valid && m_dest[i] == res_tag) begin
          m_st[i] = 0;
        end
      end
      if (fire_i) begin
        ir[0] = issue_a_ready; iv[0] = issue_a_value; it[0] = issue_a_tag;
        ir[1] = issue_b_ready; iv[1] = issue_b_value; it[1] = issue_b_tag;
        m_st[fs] = 1;
        m_op[fs] = issue_op;
        m_dest[fs] = issue_dest;
        for (int k = 0; k < 2; k++) begin
          m_tag[fs][k] = it[k];
          if (ir[k]) begin
            m_rdy[fs][k] = 1'b1; m_val[fs][k] = iv[k];
          end else if (res_valid && res_tag == it[k]) begin
            m_rdy[fs][k] = 1'b1; m_val[fs][k] = res_data;
          end else begin
            m_rdy[fs][k] = 1'b0;
          end
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put_issue(input logic [OW-1:0] op, input bit ar, input logic [31:0] av,
                           input bit br, input logic [31:0] bv, input logic [TW-1:0] d);
    issue_valid = 1'b1; issue_op = op;
    issue_a_ready = ar; issue_a_value = av; issue_a_tag = av[TW-1:0];
    issue_b_ready = br; issue_b_value = bv; issue_b_tag = bv[TW-1:0];
    issue_dest = d;
  endtask

  task automatic do_flush();
    idle_inputs(); flush = 1'b1; step(); flush = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int next_dest;
    void'($urandom(32'd5150));
    model_clear();
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(free_any === 1'b1 && disp_valid === 1'b0, "R7", "reset state", {free_any, disp_valid}, 2'b10);
    @(negedge clk);

    // R5: broadcast in the issue cycle fills the missing operand
    put_issue(4'd3, 1'b0, 32'd5, 1'b1, 32'h11, 4'd9);
    res_valid = 1'b1; res_tag = 4'd5; res_data = 32'hABCD;
    step();
    idle_inputs();
    #1;
    chk(disp_valid === 1'b1 && disp_a === 32'hABCD, "R5", "same-cycle capture", disp_a, 32'hABCD);
    step(1'b1);

    // R9: matching destination on an undispatched slot does not free it
    do_flush();
    put_issue(4'd1, 1'b1, 32'h70, 1'b1, 32'h71, 4'd7);
    step();
    idle_inputs(); res_valid = 1'b1; res_tag = 4'd7; res_data = 32'h1;
    step();
    idle_inputs();
    #1;
    chk(disp_valid === 1'b1 && disp_dest === 4'd7, "R9", "undispatched kept", 32'(disp_dest), 32'd7);
    step(1'b1);

    // R9 then R4: other tag ignored, matching tag captured
    do_flush();
    put_issue(4'd2, 1'b0, 32'd3, 1'b1, 32'h22, 4'd8);
    step();
    idle_inputs(); res_valid = 1'b1; res_tag = 4'd4; res_data = 32'h44;
    step();
    idle_inputs();
    #1;
    chk(disp_valid === 1'b0, "R9", "foreign tag ignored", 32'(disp_valid), 32'd0);
    step(1'b1);
    res_valid = 1'b1; res_tag = 4'd3; res_data = 32'h33;
    step();
    idle_inputs();
    #1;
    chk(disp_valid === 1'b1 && disp_a === 32'h33, "R4", "snoop capture", disp_a, 32'h33);
    step(1'b1);

    // R6: lowest index first, in order
    do_flush();
    for (int j = 1; j <= 3; j++) begin
      put_issue(4'(j), 1'b1, 32'(j), 1'b1, 32'(j), 4'(j));
      step();
    end
    idle_inputs(); disp_ready = 1'b1;
    for (int j = 1; j <= 3; j++) begin
      #1;
      chk(disp_valid === 1'b1 && disp_dest === 4'(j), "R6", "dispatch order", 32'(disp_dest), 32'(j));
      step(1'b1);
    end
    // R7: result frees a sent slot
    idle_inputs(); res_valid = 1'b1; res_tag = 4'd2; res_data = '0;
    step();
    idle_inputs();

    // R1 and R8: fill all slots, then flush
    do_flush();
    for (int j = 0; j < 4; j++) begin
      put_issue(4'd0, 1'b0, 32'hE, 1'b0, 32'hF, 4'(j));
      step();
    end
    idle_inputs(); issue_valid = 1'b1;
    #1;
    chk(free_any === 1'b0 && issue_ready === 1'b0, "R1", "full blocks issue", {free_any, issue_ready}, 2'b00);
    step(1'b1);
    flush = 1'b1;
    #1;
    chk(issue_ready === 1'b0 && disp_valid === 1'b0, "R8", "quiet during flush", {issue_ready, disp_valid}, 2'b00);
    step(1'b1);
    idle_inputs();
    #1;
    chk(free_any === 1'b1 && disp_valid === 1'b0, "R8", "cleared after flush", {free_any, disp_valid}, 2'b10);
    step(1'b1);

    // Random traffic
    next_dest = 0;
    for (int c = 0; c < 3000; c++) begin
      int sent_pick;
      issue_valid   = ($urandom % 10) < 6;
      rob_room      = ($urandom % 100) < 85;
      issue_op      = OW'($urandom);
      issue_a_ready = $urandom % 2;
      issue_b_ready = $urandom % 2;
      issue_a_value = $urandom;
      issue_b_value = $urandom;
      issue_a_tag   = TW'($urandom);
      issue_b_tag   = TW'($urandom);
      issue_dest    = TW'(next_dest);
      next_dest     = (next_dest + 1) % 16;
      res_valid     = ($urandom % 100) < 45;
      res_data      = $urandom;
      res_tag       = TW'($urandom);
      sent_pick     = -1;
      for (int i = 0; i < N; i++) if (m_st[i] == 2) sent_pick = i;
      if (sent_pick >= 0 && ($urandom % 2)) res_tag = m_dest[sent_pick];
      disp_ready    = ($urandom % 10) < 7;
      flush         = ($urandom % 100) < 2;
      step();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule